// File: doc/BRIEF.md
# Stretchable External Bus Cycle Controller

This block runs external memory bus cycles on behalf of a fast internal bus when the external memory is slower. Every cycle starts with an address phase, during which the E clock is low. A data phase follows, during which E is high. A two-bit setting adds 0, 1, 2 or 3 internal clocks to the data phase. The address phase is never lengthened.

While the extra clocks run, a hold output freezes the CPU sequencing logic in its current state. On a write, the write data is already on the bus before the extra clocks start and stays driven through them. On a read, the bus is sampled only at the edge where the stretched E clock falls. A one-clock done pulse then reports completion and presents the captured read data.

The stretch setting is captured when a request is accepted. A change to it during a cycle therefore affects only the cycles that follow. The external data bus is modelled as a separate input, a separate output and an output enable.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset: `eclk_o` is 0, `cs_o` is 0, `rw_o` is 1 (read), `data_oe_o` is 0, `hold_o` is 0 and `done_o` is 0.
- R2: An accepted request produces exactly one address clock first. In that clock `cs_o` is 1, `eclk_o` is 0 and `addr_o` equals the requested address. A request is accepted only while the controller is idle or in its done clock; a request raised during a cycle is ignored.
- R3: After the address clock, `eclk_o` stays 1 for exactly 1+N clocks. N is the value of `stretch_i` (0 to 3) when the request is accepted. `cs_o` is therefore high for 2+N clocks.
- R4: `hold_o` is 1 for exactly the first N clocks of E high. It is 0 in every other clock, including the address clock.
- R5: On a write (`wr_i`=1), `data_oe_o` is 1 and `data_o` equals the write data in every E-high clock, including the stretch clocks. `data_oe_o` is 0 on reads and in every clock where E is low.
- R6: `cs_o`, `rw_o` and `addr_o` stay constant from the address clock to the last E-high clock. `rw_o` is 0 for writes and 1 for reads.
- R7: On a read, `rdata_o` takes the value of `bus_rdata_i` present in the last E-high clock. Values present in earlier E-high clocks are not captured.
- R8: `done_o` is a single-clock pulse in the clock right after E falls, with `rdata_o` valid in that clock. A request present in the done clock starts the next address clock on the following clock.
- R9: A change of `stretch_i` after a request is accepted does not alter the length of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request for an external cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Request address |
| wdata_i | input | DW | Request write data |
| stretch_i | input | 2 | Extra E-high clocks, 0 to 3 |
| bus_rdata_i | input | DW | Data arriving from the external bus |
| addr_o | output | AW | External address bus |
| data_o | output | DW | Data driven onto the external bus |
| data_oe_o | output | 1 | Output enable for `data_o` |
| rw_o | output | 1 | 1 = read, 0 = write |
| cs_o | output | 1 | Chip select, active high |
| eclk_o | output | 1 | E clock |
| hold_o | output | 1 | Freeze request to the CPU during stretch clocks |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions assume that the request inputs (`wr_i`, `addr_i`, `wdata_i`, `stretch_i`) are only meaningful in the clock where the request is accepted. They also assume that the bus read data is only meaningful in the last E-high clock. The properties therefore check the controller's captured state and never require the inputs to hold steady. The bench changes `stretch_i` right after each acceptance. It drives deliberately wrong read data in every E-high clock except the last. It also raises stray requests during a busy cycle, so that the design is exercised where those assumptions are loosest.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    stretch_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rw_o,
  output logic          cs_o,
  output logic          eclk_o,
  output logic          hold_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_DONE} state_t;

  state_t        state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q;
  logic [1:0]    str_q;
  logic [1:0]    cnt_q;

  wire accept = req_i && (state == S_IDLE || state == S_DONE);
  wire last_e = (state == S_DATA) && (cnt_q == str_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      str_q   <= 2'd0;
      cnt_q   <= 2'd0;
      rdata_o <= '0;
    end else begin
      case (state)
        S_ADDR: begin
          state <= S_DATA;
          cnt_q <= 2'd0;
        end
        S_DATA: begin
          if (last_e) begin
            state <= S_DONE;
            if (!wr_q) rdata_o <= bus_rdata_i;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        default: begin
          if (accept) begin
            state   <= S_ADDR;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            wr_q    <= wr_i;
            str_q   <= stretch_i;
          end else begin
            state <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign cs_o      = (state == S_ADDR) || (state == S_DATA);
  assign eclk_o    = (state == S_DATA);
  assign hold_o    = eclk_o && !last_e;
  assign rw_o      = !(cs_o && wr_q);
  assign data_oe_o = eclk_o && wr_q;
  assign data_o    = wdata_q;
  assign addr_o    = addr_q;
  assign done_o    = (state == S_DONE);

  AST_ADDR_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> !eclk_o && !hold_o);                                   // R2
  AST_ADDR_PHASE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |=> eclk_o);                                               // R2
  AST_E_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    eclk_o |-> cs_o);                                                      // R3
  AST_HOLD_IN_E: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |=> eclk_o);                                                    // R4
  AST_OE_WRITE_E: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> eclk_o && !rw_o);                                        // R5
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o && $past(data_oe_o) |-> $stable(data_o));                    // R5
  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    eclk_o |-> $stable(rw_o) && $stable(addr_o) && $past(cs_o));           // R6
  AST_DONE_AFTER_E: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(eclk_o) && !eclk_o);                                  // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                                   // R8
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o && !$past(done_o) |-> $stable(rdata_o));                       // R7

endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NV = 8;

  // {wr, stretch, addr, wdata, bus read value}
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h1000, 16'h0000, 16'hA5A5},
    {1'b1, 2'd0, 16'h1002, 16'h1234, 16'h0000},
    {1'b0, 2'd1, 16'h2001, 16'h0000, 16'h5A5A},
    {1'b1, 2'd1, 16'h2003, 16'hBEEF, 16'h0000},
    {1'b0, 2'd2, 16'h3FFE, 16'h0000, 16'hC3C3},
    {1'b1, 2'd2, 16'h4000, 16'h0F0F, 16'h0000},
    {1'b0, 2'd3, 16'hFFFF, 16'h0000, 16'h7E81},
    {1'b1, 2'd3, 16'h8001, 16'hF00D, 16'h0000}
  };

  logic clk = 0, rst_n = 0;
  logic req_i = 0, wr_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0, bus_rdata_i = '0;
  logic [1:0] stretch_i = '0;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o, rdata_o;
  logic data_oe_o, rw_o, cs_o, eclk_o, hold_o, done_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ext_bus_seq #(.AW(AW), .DW(DW)) i_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .stretch_i(stretch_i), .bus_rdata_i(bus_rdata_i),
    .addr_o(addr_o), .data_o(data_o), .data_oe_o(data_oe_o), .rw_o(rw_o),
    .cs_o(cs_o), .eclk_o(eclk_o), .hold_o(hold_o), .rdata_o(rdata_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle_outputs(input string req);
    chk(eclk_o == 0, req, eclk_o, 0);
    chk(cs_o == 0, req, cs_o, 0);
    chk(rw_o == 1, req, rw_o, 1);
    chk(data_oe_o == 0, req, data_oe_o, 0);
    chk(hold_o == 0, req, hold_o, 0);
  endtask

  // One complete cycle; the request is raised at the current negedge.
  task automatic run_cycle(input logic wr, input logic [1:0] st, input logic [15:0] a,
                           input logic [15:0] wd, input logic [15:0] rd, input bit keep_req);
    req_i = 1; wr_i = wr; stretch_i = st; addr_i = a; wdata_i = wd;
    @(negedge clk);
    if (!keep_req) req_i = 0;
    stretch_i = ~st;                         // R9 mid-cycle change
    addr_i = ~a; wdata_i = ~wd; wr_i = ~wr;
    chk(cs_o == 1 && eclk_o == 0, "R2 addr clock", {cs_o, eclk_o}, 2'b10);
    chk(addr_o == a, "R2 address", addr_o, a);
    chk(hold_o == 0 && data_oe_o == 0, "R4/R5 addr clock", {hold_o, data_oe_o}, 2'b00);
    chk(rw_o == !wr, "R6 rw", rw_o, !wr);
    for (int i = 0; i <= st; i++) begin
      @(negedge clk);
      bus_rdata_i = (i == st) ? rd : ~rd;    // R7 only the last E-high value counts
      chk(eclk_o == 1, "R3/R9 E high length", eclk_o, 1);
      chk(cs_o == 1 && addr_o == a && rw_o == !wr, "R6 stable", {cs_o, rw_o, addr_o}, {1'b1, !wr, a});
      chk(hold_o == (i < st), "R4 hold", hold_o, (i < st));
      chk(data_oe_o == wr, "R5 oe", data_oe_o, wr);
      if (wr) chk(data_o == wd, "R5 write data", data_o, wd);
      chk(done_o == 0, "R8 no early done", done_o, 0);
    end
    @(negedge clk);
    chk(eclk_o == 0, "R3 E falls after 1+N", eclk_o, 0);
    chk(done_o == 1, "R8 done", done_o, 1);
    chk(data_oe_o == 0 && hold_o == 0, "R5/R4 after E", {data_oe_o, hold_o}, 2'b00);
    if (!wr) chk(rdata_o == rd, "R7 read capture", rdata_o, rd);
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle_outputs("R1 reset");
    chk(done_o == 0, "R1 reset done", done_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk_idle_outputs("R1 after release");

    for (int v = 0; v < NV; v++) begin
      run_cycle(VEC[v][50], VEC[v][49:48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0], 0);
      @(negedge clk);
      chk(done_o == 0, "R8 done single", done_o, 0);
      chk_idle_outputs("R8 idle after done");
    end

    // R2: request raised only during a busy cycle is ignored
    req_i = 1; wr_i = 0; stretch_i = 2'd2; addr_i = 16'h0123;
    @(negedge clk);
    req_i = 0;
    @(negedge clk);
    req_i = 1;                               // stray request in E high
    @(negedge clk);
    req_i = 0;
    repeat (2) @(negedge clk);
    chk(done_o == 1, "R8 done after stretch 2", done_o, 1);
    repeat (3) begin
      @(negedge clk);
      chk(cs_o == 0, "R2 busy request ignored", cs_o, 0);
    end

    // R8: request held through done starts the next cycle right after it
    run_cycle(1'b1, 2'd1, 16'h5555, 16'hAAAA, 16'h0000, 1);
    req_i = 1; wr_i = 0; stretch_i = 2'd0; addr_i = 16'h6666;
    @(negedge clk);
    req_i = 0;
    chk(cs_o == 1 && eclk_o == 0 && addr_o == 16'h6666, "R8 back-to-back",
        {cs_o, eclk_o, addr_o}, {2'b10, 16'h6666});
    repeat (3) @(negedge clk);

    // R1: reset in the middle of a stretched write
    req_i = 1; wr_i = 1; stretch_i = 2'd3; addr_i = 16'h7777; wdata_i = 16'h9999;
    @(negedge clk);
    req_i = 0;
    repeat (2) @(negedge clk);
    chk(hold_o == 1, "R4 hold mid stretch", hold_o, 1);
    rst_n = 0;
    #1;
    chk_idle_outputs("R1 mid-cycle reset");
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk_idle_outputs("R1 idle after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    finished = 1;
    $finish;
  end
endmodule